// File: doc/BRIEF.md
# LED open-detect status capture controller

This block is the digital control slice of a 16-channel constant-current LED driver. It decides, clock by clock, whether the raw per-channel open-LED detector vector is captured into a 16-bit status holder or whether the holder keeps its value. On a latch strobe it also fills a 17-bit common shift register in parallel, either with the held detector status or with the latched channel on/off pattern. The serial shifting itself happens outside the block.

A short diagnostic drive can run after each release of blanking. During that window every channel is driven at a selectable diagnostic current, whatever its normal on/off bit says. The window length comes from a 2-bit duration select. Once the window ends, the detector view reads as zero and the holder stops tracking. A settling mask keeps the first few clocks after blanking falls away from the holder, because the detectors give unstable values at that time. All outputs are registered, so each one reflects the inputs seen at the previous rising clock edge.

Top module: `ledstat_ctrl`

## Requirements
- R1: When `rst_n` is low at a rising edge, every output is zero after that edge (`chan_on_o`, `dcur_o`, `det_view_o`, `status_o`, `sr_o`, `sr_load_o`, `expired_o`). The block then treats blanking as previously high.
- R2: An edge that sees `blank_i` high makes `chan_on_o`, `dcur_o` and `det_view_o` all zero after it, even when a diagnostic window is still running.
- R3: An edge that sees `blank_i` high leaves `status_o` unchanged.
- R4: The edge that first sees `blank_i` low after it was high is the fall edge. Neither the fall edge nor the next MASK-1 edges (default 4 edges in total) change `status_o`. From the MASK-th edge after the fall edge, `status_o` takes `det_i`, provided no other freeze applies.
- R5: If `dcur_sel_i` is nonzero at the fall edge, a diagnostic window starts. For 8 << `dur_sel_i` edges, counted from the fall edge (8, 16, 32 or 64), `chan_on_o` is all ones and `dcur_o` holds the captured code (01 = 2 mA, 10 = 10 mA, 11 = 20 mA). After the next edge `expired_o` is 1 and `dcur_o` is 0.
- R6: While `expired_o` is 1, `det_view_o` is zero and `status_o` is frozen. `expired_o` clears after the first edge that sees `blank_i` high.
- R7: If `dcur_sel_i` is 00 at the fall edge, there is no diagnostic drive and no expiry. `status_o` keeps following `det_i` for as long as blanking stays low.
- R8: An edge that sees `latch_i` high with `rdsel_i` = 01 sets `sr_o` to {0, `status_o` as it was before that edge}. `sr_load_o` is high for exactly the cycle after each edge that sees `latch_i` high. `sr_o` does not change otherwise.
- R9: An edge that sees `latch_i` high with `rdsel_i` equal to 00, 10 or 11 sets `sr_o` to {0, `onoff_i`}.
- R10: When blanking is low and no diagnostic window runs, `chan_on_o` equals `onoff_i`. Unless expired, `det_view_o` equals `det_i`. Both take the values seen at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blank_i | input | 1 | Blanking; high forces all channels off |
| latch_i | input | 1 | Latch strobe that loads the common shift register |
| rdsel_i | input | 2 | Readback select; 01 loads detector status |
| det_i | input | 16 | Raw open-LED detector vector |
| onoff_i | input | 16 | Latched channel on/off pattern |
| dcur_sel_i | input | 2 | Diagnostic current code; 00 disables diagnostics |
| dur_sel_i | input | 2 | Diagnostic window length select |
| chan_on_o | output | 16 | Per-channel drive enable |
| dcur_o | output | 2 | Diagnostic current code being applied |
| det_view_o | output | 16 | Gated detector output |
| status_o | output | 16 | Status holder contents |
| sr_o | output | 17 | Parallel load value of the common shift register |
| sr_load_o | output | 1 | One-cycle pulse marking a shift register load |
| expired_o | output | 1 | Diagnostic window has ended |

## Verification
Suppose the window counter or its captured select is wrong. `chan_on_o` and `dcur_o` then drop at the wrong edge, and `expired_o` rises early or late. The window check counts edges exactly, so it sees the error within the 64-cycle longest window. A stuck settle counter or a missing freeze condition shows on the very next edge, because `status_o` changes where it must hold. A stale holder appears one edge after a status latch, as a wrong `sr_o`.

// File: rtl/ledstat_pkg.sv
package ledstat_pkg;

    typedef enum logic [1:0] {
        RD_ONOFF  = 2'b00,
        RD_STATUS = 2'b01,
        RD_RSV_A  = 2'b10,
        RD_RSV_B  = 2'b11
    } rdsel_e;

    typedef enum logic [1:0] {
        DC_OFF  = 2'b00,
        DC_LOW  = 2'b01,
        DC_MID  = 2'b10,
        DC_HIGH = 2'b11
    } dcur_e;

endpackage

// File: rtl/lsc_diag_timer.sv
module lsc_diag_timer #(
    parameter int DUR_BASE = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blank_i,
    input  logic       fall_i,
    input  logic [1:0] cur_i,
    input  logic [1:0] dur_i,
    output logic       run_nxt_o,
    output logic       exp_nxt_o,
    output logic [1:0] cur_nxt_o
);
    import ledstat_pkg::*;

    localparam int CNT_W = $clog2(DUR_BASE * 8);

    typedef struct packed {
        logic             run;
        logic             exp;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       cur;
        logic [1:0]       dur;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    function automatic logic [CNT_W-1:0] last_of(input logic [1:0] s);
        return CNT_W'((DUR_BASE << s) - 1);
    endfunction

    always_comb begin
        tmr_d = tmr_q;
        if (blank_i) begin
            tmr_d = '0;
        end else if (fall_i) begin
            tmr_d = '0;
            if (dcur_e'(cur_i) != DC_OFF) begin
                tmr_d.run = 1'b1;
                tmr_d.cur = cur_i;
                tmr_d.dur = dur_i;
            end
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == last_of(tmr_q.dur)) begin
                tmr_d.run = 1'b0;
                tmr_d.exp = 1'b1;
                tmr_d.cur = DC_OFF;
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign run_nxt_o = tmr_d.run;
    assign exp_nxt_o = tmr_d.exp;
    assign cur_nxt_o = tmr_d.cur;

endmodule

// File: rtl/lsc_settle_mask.sv
module lsc_settle_mask #(
    parameter int MASK = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blank_i,
    input  logic fall_i,
    output logic masked_o
);
    generate
        if (MASK <= 1) begin : g_edge_only
            assign masked_o = fall_i;
        end else begin : g_counter
            localparam int MW = $clog2(MASK);

            typedef struct packed {
                logic [MW-1:0] left;
            } msk_s;

            msk_s msk_d, msk_q;

            always_comb begin
                msk_d = msk_q;
                if (blank_i)                msk_d.left = '0;
                else if (fall_i)            msk_d.left = MW'(MASK - 1);
                else if (msk_q.left != '0)  msk_d.left = msk_q.left - 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) msk_q <= '0;
                else        msk_q <= msk_d;
            end

            assign masked_o = fall_i | (msk_q.left != '0);
        end
    endgenerate

endmodule

// File: rtl/lsc_readback.sv
module lsc_readback #(
    parameter int CH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_i,
    input  logic [CH-1:0] det_i,
    input  logic          latch_i,
    input  logic [1:0]    rdsel_i,
    input  logic [CH-1:0] onoff_i,
    output logic [CH-1:0] hold_o,
    output logic [CH:0]   sr_o,
    output logic          load_o
);
    import ledstat_pkg::*;

    typedef struct packed {
        logic [CH-1:0] hold;
        logic [CH:0]   sr;
        logic          load;
    } rb_s;

    rb_s rb_d, rb_q;

    always_comb begin
        rb_d      = rb_q;
        rb_d.load = latch_i;
        if (sample_i) rb_d.hold = det_i;
        if (latch_i) begin
            if (rdsel_e'(rdsel_i) == RD_STATUS) rb_d.sr = {1'b0, rb_q.hold};
            else                                rb_d.sr = {1'b0, onoff_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    assign hold_o = rb_q.hold;
    assign sr_o   = rb_q.sr;
    assign load_o = rb_q.load;

endmodule

// File: rtl/ledstat_ctrl.sv
module ledstat_ctrl #(
    parameter int CH       = 16,
    parameter int MASK     = 4,
    parameter int DUR_BASE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blank_i,
    input  logic          latch_i,
    input  logic [1:0]    rdsel_i,
    input  logic [CH-1:0] det_i,
    input  logic [CH-1:0] onoff_i,
    input  logic [1:0]    dcur_sel_i,
    input  logic [1:0]    dur_sel_i,
    output logic [CH-1:0] chan_on_o,
    output logic [1:0]    dcur_o,
    output logic [CH-1:0] det_view_o,
    output logic [CH-1:0] status_o,
    output logic [CH:0]   sr_o,
    output logic          sr_load_o,
    output logic          expired_o
);
    typedef struct packed {
        logic          blank_prev;
        logic [CH-1:0] chan_on;
        logic [1:0]    dcur;
        logic [CH-1:0] view;
        logic          exp;
    } top_s;

    localparam top_s TOP_RST = '{blank_prev: 1'b1, default: '0};

    top_s top_d, top_q;

    logic       fall;
    logic       masked;
    logic       sample_en;
    logic       run_nxt;
    logic       exp_nxt;
    logic [1:0] cur_nxt;

    assign fall      = top_q.blank_prev & ~blank_i;
    assign sample_en = ~blank_i & ~masked & ~exp_nxt;

    lsc_diag_timer #(.DUR_BASE(DUR_BASE)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .blank_i   (blank_i),
        .fall_i    (fall),
        .cur_i     (dcur_sel_i),
        .dur_i     (dur_sel_i),
        .run_nxt_o (run_nxt),
        .exp_nxt_o (exp_nxt),
        .cur_nxt_o (cur_nxt)
    );

    lsc_settle_mask #(.MASK(MASK)) u_msk (
        .clk      (clk),
        .rst_n    (rst_n),
        .blank_i  (blank_i),
        .fall_i   (fall),
        .masked_o (masked)
    );

    lsc_readback #(.CH(CH)) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_en),
        .det_i    (det_i),
        .latch_i  (latch_i),
        .rdsel_i  (rdsel_i),
        .onoff_i  (onoff_i),
        .hold_o   (status_o),
        .sr_o     (sr_o),
        .load_o   (sr_load_o)
    );

    always_comb begin
        top_d            = top_q;
        top_d.blank_prev = blank_i;
        top_d.exp        = exp_nxt;
        if (blank_i) begin
            top_d.chan_on = '0;
            top_d.dcur    = '0;
            top_d.view    = '0;
        end else begin
            top_d.chan_on = run_nxt ? '1 : onoff_i;
            top_d.dcur    = run_nxt ? cur_nxt : 2'b00;
            top_d.view    = exp_nxt ? '0 : det_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= TOP_RST;
        else        top_q <= top_d;
    end

    assign chan_on_o  = top_q.chan_on;
    assign dcur_o     = top_q.dcur;
    assign det_view_o = top_q.view;
    assign expired_o  = top_q.exp;

endmodule

// File: rtl/ledstat_ctrl_chk.sv
module ledstat_ctrl_chk #(
    parameter int CH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          blank_i,
    input logic          latch_i,
    input logic [1:0]    rdsel_i,
    input logic [CH-1:0] onoff_i,
    input logic [CH-1:0] chan_on_o,
    input logic [1:0]    dcur_o,
    input logic [CH-1:0] det_view_o,
    input logic [CH-1:0] status_o,
    input logic [CH:0]   sr_o,
    input logic          sr_load_o,
    input logic          expired_o
);
    p_blank_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |=> (chan_on_o == '0 && dcur_o == 2'b00 && det_view_o == '0));

    p_hold_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |=> $stable(status_o));

    p_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blank_i) |=> $stable(status_o));

    p_diag_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dcur_o != 2'b00) |-> (chan_on_o == '1));

    p_exp_view_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |-> (det_view_o == '0 && dcur_o == 2'b00));

    p_exp_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !blank_i) |=> $stable(status_o));

    p_load_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |=> sr_load_o);

    p_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_i |=> (!sr_load_o && $stable(sr_o)));

    p_status_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && rdsel_i == 2'b01) |=> (sr_o == {1'b0, $past(status_o)}));

    p_onoff_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_i && rdsel_i != 2'b01) |=> (sr_o == {1'b0, $past(onoff_i)}));

endmodule

bind ledstat_ctrl ledstat_ctrl_chk #(.CH(CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .blank_i    (blank_i),
    .latch_i    (latch_i),
    .rdsel_i    (rdsel_i),
    .onoff_i    (onoff_i),
    .chan_on_o  (chan_on_o),
    .dcur_o     (dcur_o),
    .det_view_o (det_view_o),
    .status_o   (status_o),
    .sr_o       (sr_o),
    .sr_load_o  (sr_load_o),
    .expired_o  (expired_o)
);

// File: tb/sim_ledstat_ctrl.sv
`timescale 1ns/1ps
module sim_ledstat_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        blank_i;
    logic        latch_i;
    logic [1:0]  rdsel_i;
    logic [15:0] det_i;
    logic [15:0] onoff_i;
    logic [1:0]  dcur_sel_i;
    logic [1:0]  dur_sel_i;
    logic [15:0] chan_on_o;
    logic [1:0]  dcur_o;
    logic [15:0] det_view_o;
    logic [15:0] status_o;
    logic [16:0] sr_o;
    logic        sr_load_o;
    logic        expired_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ledstat_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .blank_i(blank_i), .latch_i(latch_i),
        .rdsel_i(rdsel_i), .det_i(det_i), .onoff_i(onoff_i),
        .dcur_sel_i(dcur_sel_i), .dur_sel_i(dur_sel_i),
        .chan_on_o(chan_on_o), .dcur_o(dcur_o), .det_view_o(det_view_o),
        .status_o(status_o), .sr_o(sr_o), .sr_load_o(sr_load_o),
        .expired_o(expired_o)
    );

    typedef struct packed {
        logic [15:0] det;
        logic [15:0] onoff;
        logic [1:0]  sel;
        logic        latch;
        logic [15:0] x_view;
        logic [15:0] x_chan;
        logic [16:0] x_sr;
        logic        x_load;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{16'h1234, 16'h00FF, 2'b00, 1'b1, 16'h1234, 16'h00FF, 17'h000FF, 1'b1},
        '{16'h5678, 16'hF0F0, 2'b01, 1'b1, 16'h5678, 16'hF0F0, 17'h01234, 1'b1},
        '{16'h9ABC, 16'h0F0F, 2'b01, 1'b0, 16'h9ABC, 16'h0F0F, 17'h01234, 1'b0},
        '{16'hDEF0, 16'hAAAA, 2'b01, 1'b1, 16'hDEF0, 16'hAAAA, 17'h09ABC, 1'b1},
        '{16'h0001, 16'h5555, 2'b10, 1'b1, 16'h0001, 16'h5555, 17'h05555, 1'b1},
        '{16'hFFFF, 16'h0000, 2'b11, 1'b1, 16'hFFFF, 16'h0000, 17'h00000, 1'b1},
        '{16'h8000, 16'hFFFF, 2'b01, 1'b1, 16'h8000, 16'hFFFF, 17'h0FFFF, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        finish_run();
    end

    initial begin
        int runs;
        int first_exp;
        rst_n = 0; blank_i = 1; latch_i = 0; rdsel_i = 0; det_i = 0;
        onoff_i = 0; dcur_sel_i = 0; dur_sel_i = 0;
        tick(); tick(); tick();
        // R1: reset state
        chk("R1 chan", 32'(chan_on_o), 0);
        chk("R1 dcur", 32'(dcur_o), 0);
        chk("R1 view", 32'(det_view_o), 0);
        chk("R1 status", 32'(status_o), 0);
        chk("R1 sr", 32'(sr_o), 0);
        chk("R1 load", 32'(sr_load_o), 0);
        chk("R1 exp", 32'(expired_o), 0);
        rst_n = 1;
        tick();

        // R4: settle mask after the fall edge, diagnostics off
        det_i = 16'hA5A5; onoff_i = 16'h00F0; blank_i = 0;
        tick();
        chk("R4 status at fall edge", 32'(status_o), 0);
        chk("R10 view", 32'(det_view_o), 32'hA5A5);
        chk("R10 chan", 32'(chan_on_o), 32'h00F0);
        for (int k = 1; k < 4; k++) begin
            tick();
            chk("R4 status masked", 32'(status_o), 0);
        end
        tick();
        chk("R4 status first sample", 32'(status_o), 32'hA5A5);

        // R7: diagnostics disabled, holder keeps tracking
        for (int k = 0; k < 80; k++) begin
            det_i = 16'(k * 16'h0101 + 3);
            tick();
            chk("R7 status follows", 32'(status_o), 32'(det_i));
            chk("R7 no expiry", 32'(expired_o), 0);
            chk("R7 no diag current", 32'(dcur_o), 0);
        end
        chk("R7 chan normal", 32'(chan_on_o), 32'h00F0);

        // R2/R3: blanking forces off and freezes holder
        blank_i = 1; det_i = 16'h1234;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R2 chan off", 32'(chan_on_o), 0);
            chk("R2 view zero", 32'(det_view_o), 0);
            chk("R3 frozen", 32'(status_o), 32'(16'(79 * 16'h0101 + 3)));
        end

        // R8/R9/R10: vector table
        blank_i = 0; det_i = 16'h1111;
        for (int k = 0; k < 5; k++) tick();
        chk("R4 settled", 32'(status_o), 32'h1111);
        foreach (VECS[i]) begin
            det_i = VECS[i].det; onoff_i = VECS[i].onoff;
            rdsel_i = VECS[i].sel; latch_i = VECS[i].latch;
            tick();
            chk("R10 view vec", 32'(det_view_o), 32'(VECS[i].x_view));
            chk("R10 chan vec", 32'(chan_on_o), 32'(VECS[i].x_chan));
            chk("R8 R9 sr vec", 32'(sr_o), 32'(VECS[i].x_sr));
            chk("R8 load vec", 32'(sr_load_o), 32'(VECS[i].x_load));
        end
        latch_i = 0;
        tick();
        chk("R8 load ends", 32'(sr_load_o), 0);

        // R5/R6: diagnostic window of 8 edges at code 10
        blank_i = 1; tick();
        dcur_sel_i = 2'b10; dur_sel_i = 2'b00; onoff_i = 16'h0000;
        det_i = 16'hC0C0; blank_i = 0;
        for (int k = 0; k < 8; k++) begin
            if (k == 7) det_i = 16'hD0D0;
            tick();
            chk("R5 diag chan", 32'(chan_on_o), 32'hFFFF);
            chk("R5 diag code", 32'(dcur_o), 32'h2);
            chk("R5 not expired", 32'(expired_o), 0);
        end
        chk("R5 sampled in window", 32'(status_o), 32'hD0D0);
        det_i = 16'hE0E0;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R5 expired", 32'(expired_o), 1);
            chk("R5 code off", 32'(dcur_o), 0);
            chk("R10 chan after window", 32'(chan_on_o), 0);
            chk("R6 view zero", 32'(det_view_o), 0);
            chk("R6 frozen", 32'(status_o), 32'hD0D0);
        end
        blank_i = 1; tick();
        chk("R6 expiry clears", 32'(expired_o), 0);

        // R5: longest window, code 01
        dcur_sel_i = 2'b01; dur_sel_i = 2'b11; blank_i = 0;
        runs = 0; first_exp = -1;
        for (int k = 0; k < 70; k++) begin
            tick();
            if (dcur_o == 2'b01) runs++;
            if (expired_o && first_exp < 0) first_exp = k;
        end
        chk("R5 window length 64", 32'(runs), 64);
        chk("R5 expiry edge", 32'(first_exp), 64);

        // R2: blanking mid-window, code 11, 16 edges
        blank_i = 1; tick();
        dcur_sel_i = 2'b11; dur_sel_i = 2'b01; blank_i = 0;
        for (int k = 0; k < 5; k++) tick();
        chk("R5 code 11 running", 32'(dcur_o), 32'h3);
        blank_i = 1; tick();
        chk("R2 mid-window chan off", 32'(chan_on_o), 0);
        chk("R2 mid-window code off", 32'(dcur_o), 0);

        // R1: reset during a running window
        blank_i = 0; tick(); tick(); tick();
        rst_n = 0; tick();
        chk("R1 mid reset chan", 32'(chan_on_o), 0);
        chk("R1 mid reset code", 32'(dcur_o), 0);
        chk("R1 mid reset status", 32'(status_o), 0);
        chk("R1 mid reset sr", 32'(sr_o), 0);
        rst_n = 1; blank_i = 1; tick();

        finish_run();
    end

endmodule